// File: doc/BRIEF.md
# NAND Flash Host Operation Sequencer

This block sits on the host side of a NAND flash device that shares one 8-bit bus for commands, addresses and data. A requester hands it one high-level operation at a time: page read, page program, block erase, read identification, read status or device reset. The sequencer turns each operation into the right series of bus cycles. It holds chip-enable low for the whole operation and raises the command-latch or address-latch line as each byte needs. Every byte is strobed with write-enable, and read bytes are fetched with read-enable. Program data is pulled from the requester through a valid/ready byte handshake. Read data is handed back one byte per `rd_valid` pulse.

Between the end of an operation and its completion check, the sequencer watches the ready/busy line. A programmable count bounds that wait and raises an error if it runs out. After a program or erase it issues a read-status command and returns the device status byte. While an erase is in progress the requester may ask for a suspend. The read command byte is picked from the requested column, so that the device's internal pointer lands on the first half, the second half or the spare area of the page. Strobe setup, low and high times are clock-count parameters.

Top module: `nand_seq`

## Requirements
- R1: Chip-enable (`nand_ce_n`, active low) is low during every write-enable or read-enable low pulse. Command bytes are driven with `nand_cle`=1 and `nand_ale`=0. Address bytes use `nand_cle`=0 and `nand_ale`=1. Program data uses both at 0. The device takes each byte on the rising edge of `nand_we_n`. `nand_dq_oe` is low whenever `nand_re_n` is low.
- R2: Page read and page program send three address bytes after the first command, in this order: `col[7:0]`, `row[7:0]`, then `{3'b000,row[12:8]}`.
- R3: Block erase (op code 2) sends 60h, then `row[7:0]` and `{3'b000,row[12:8]}` as address bytes, then D0h.
- R4: Page program (op code 1) sends 80h, then the three address bytes, then `req_len` data bytes in the order they are taken on `wr_valid`/`wr_ready`, then 10h.
- R5: The first command of a page read (op code 0) is 00h for columns 0 to 255, 01h for columns 256 to 511, and 50h for columns 512 to 527.
- R6: After a program or erase, the block waits at least `T_WB` clocks and until `nand_rb_n` is high. It then sends 70h, reads one byte, and presents it on `status` when `done` pulses.
- R7: Every write-enable and read-enable low pulse lasts exactly `T_WL` clocks. It is preceded by `T_SETUP` clocks with the latch lines and data settled, and followed by `T_WH` clocks high.
- R8: `req_ready` is high only while the block is idle, so a single request is taken at a time. It drops the cycle after acceptance and returns the cycle after the one-clock `done` pulse.
- R9: If `nand_rb_n` stays low for `TIMEOUT` clocks while the block is waiting, the operation ends with `done` and `timeout_err` set. `timeout_err` clears when the next request is accepted.
- R10: If `erase_suspend` is high while an erase waits on busy, 70h is not sent yet. B0h is sent once, the block waits for ready again, and then reads status.
- R11: Read ID (op code 3) sends 90h, one address byte 00h, then reads `req_len` bytes. Reset (op code 5) sends FFh and then waits for ready.
- R12: Read status (op code 4, also used for the unused codes 6 and 7) sends 70h at once, without waiting on `nand_rb_n`. It returns the byte on `status`.
- R13: A page read waits for ready after its address bytes. It then reads `req_len` bytes (1 to 528) and passes each one on `rd_data` with a one-clock `rd_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request taken this cycle if valid |
| req_op | input | 3 | Operation: 0 read, 1 program, 2 erase, 3 ID, 4 status, 5 reset |
| req_col | input | 10 | Column address (0 to 527) |
| req_row | input | 13 | Row (page) address |
| req_len | input | 10 | Byte count for read, program and ID |
| erase_suspend | input | 1 | Suspend a running erase |
| wr_data | input | 8 | Program data byte |
| wr_valid | input | 1 | Program data byte available |
| wr_ready | output | 1 | Program data byte taken this cycle if valid |
| rd_data | output | 8 | Read data byte |
| rd_valid | output | 1 | Read data byte strobe |
| done | output | 1 | One-clock end-of-operation pulse |
| status | output | 8 | Last status byte read from the device |
| timeout_err | output | 1 | Busy wait exceeded its limit |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write enable, active low |
| nand_re_n | output | 1 | Read enable, active low |
| nand_dq_o | output | 8 | Bus data driven to the device |
| nand_dq_oe | output | 1 | Bus output enable |
| nand_dq_i | input | 8 | Bus data from the device |
| nand_rb_n | input | 1 | Ready (1) / busy (0) from the device |

## Verification
The bench builds the block with `T_SETUP`=2, `T_WL`=2, `T_WH`=1, `T_WB`=3 and `TIMEOUT`=200. Strobes longer than one clock are needed to measure pulse widths. With the small timeout, a device model that stays busy for 500 clocks trips the error within a short run. The model then stays busy long enough to show that read status is issued without a wait. A busy time of 100 clocks on erase leaves room to raise the suspend request, and reads at columns 5, 300 and 515 cover all three read pointer commands.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;
  localparam int COL_W = 10;
  localparam int ROW_W = 13;
  localparam int LEN_W = 10;

  typedef enum logic [2:0] {
    OP_READ = 3'd0, OP_PROG = 3'd1, OP_ERASE = 3'd2,
    OP_ID = 3'd3, OP_STATUS = 3'd4, OP_RESET = 3'd5
  } op_e;

  typedef enum logic [1:0] {K_CMD, K_ADDR, K_WR, K_RD} kind_e;

  // pointer command chosen by which part of the page the column falls in
  function automatic logic [7:0] read_ptr(input logic [COL_W-1:0] col);
    if (col >= COL_W'(512)) return 8'h50;
    else if (col >= COL_W'(256)) return 8'h01;
    else return 8'h00;
  endfunction

  function automatic logic [7:0] first_cmd(input op_e op, input logic [COL_W-1:0] col);
    case (op)
      OP_READ:  return read_ptr(col);
      OP_PROG:  return 8'h80;
      OP_ERASE: return 8'h60;
      OP_ID:    return 8'h90;
      OP_RESET: return 8'hFF;
      default:  return 8'h70;
    endcase
  endfunction

  function automatic logic [1:0] addr_count(input op_e op);
    case (op)
      OP_READ, OP_PROG: return 2'd3;
      OP_ERASE:         return 2'd2;
      OP_ID:            return 2'd1;
      default:          return 2'd0;
    endcase
  endfunction

  function automatic logic [7:0] addr_byte(input op_e op, input logic [COL_W-1:0] col,
                                           input logic [ROW_W-1:0] row, input logic [1:0] idx);
    logic [7:0] hi;
    hi = 8'(row >> 8);
    if (op == OP_ID) return 8'h00;
    if (op == OP_ERASE) return (idx == 2'd0) ? row[7:0] : hi;
    case (idx)
      2'd0:    return col[7:0];
      2'd1:    return row[7:0];
      default: return hi;
    endcase
  endfunction
endpackage

// File: rtl/nand_bus_cycle.sv
module nand_bus_cycle
  import nand_seq_pkg::*;
#(
  parameter int T_SETUP = 1,
  parameter int T_WL    = 1,
  parameter int T_WH    = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  kind_e      go_kind,
  input  logic [7:0] go_byte,
  input  logic [7:0] dq_i,
  output logic       idle,
  output logic       cyc_done,
  output logic       cle,
  output logic       ale,
  output logic       we_n,
  output logic       re_n,
  output logic [7:0] dq_o,
  output logic       dq_oe,
  output logic [7:0] rd_byte
);
  localparam int MAXT = (T_SETUP > T_WL) ? ((T_SETUP > T_WH) ? T_SETUP : T_WH)
                                         : ((T_WL > T_WH) ? T_WL : T_WH);
  localparam int CW = $clog2(MAXT + 1);

  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_LOW, PH_HIGH} ph_e;
  ph_e ph;
  logic [CW-1:0] cnt;
  kind_e kind_q;
  logic [7:0] byte_q;

  logic strobe_rise;
  assign strobe_rise = (ph == PH_LOW) && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= PH_IDLE; cnt <= '0; kind_q <= K_CMD; byte_q <= '0; rd_byte <= '0;
    end else begin
      case (ph)
        PH_IDLE: if (go) begin
          kind_q <= go_kind; byte_q <= go_byte; ph <= PH_SETUP; cnt <= CW'(T_SETUP - 1);
        end
        PH_SETUP: if (cnt == '0) begin ph <= PH_LOW; cnt <= CW'(T_WL - 1); end
                  else cnt <= cnt - 1'b1;
        PH_LOW: if (cnt == '0) begin
          ph <= PH_HIGH; cnt <= CW'(T_WH - 1);
          if (kind_q == K_RD) rd_byte <= dq_i;
        end else cnt <= cnt - 1'b1;
        default: if (cnt == '0) ph <= PH_IDLE; else cnt <= cnt - 1'b1;
      endcase
    end
  end

  assign idle     = (ph == PH_IDLE);
  assign cyc_done = (ph == PH_HIGH) && (cnt == '0);
  assign cle      = (ph != PH_IDLE) && (kind_q == K_CMD);
  assign ale      = (ph != PH_IDLE) && (kind_q == K_ADDR);
  assign we_n     = !((ph == PH_LOW) && (kind_q != K_RD));
  assign re_n     = !((ph == PH_LOW) && (kind_q == K_RD));
  assign dq_o     = byte_q;
  assign dq_oe    = (ph != PH_IDLE) && (kind_q != K_RD);

  // width of the current low pulse, kept for the check below
  logic [CW:0] low_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_run <= '0;
    else if (ph == PH_LOW && !strobe_rise) low_run <= low_run + 1'b1;
    else low_run <= '0;
  end

  AST_GO_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n) go |-> idle); // R1
  AST_HOLD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_LOW) |-> ($stable(byte_q) && $stable(kind_q))); // R1
  AST_LOW_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_rise |-> (low_run == (CW+1)'(T_WL - 1))); // R7
endmodule

// File: rtl/nand_rb_wait.sv
module nand_rb_wait #(
  parameter int T_WB    = 2,
  parameter int TIMEOUT = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic rb_n,
  output logic ready_seen,
  output logic tmo
);
  localparam int MAXC = (TIMEOUT > T_WB) ? TIMEOUT : T_WB;
  localparam int WW = $clog2(MAXC + 1);
  logic [WW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (!arm) cnt <= '0;
    else if (cnt != WW'(MAXC)) cnt <= cnt + 1'b1;
  end

  assign ready_seen = arm && rb_n && (cnt >= WW'(T_WB));
  assign tmo        = arm && !rb_n && (cnt >= WW'(TIMEOUT));

  AST_TMO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    tmo |-> ($past(arm) && !ready_seen)); // R9
endmodule

// File: rtl/nand_seq.sv
module nand_seq
  import nand_seq_pkg::*;
#(
  parameter int T_SETUP = 1,
  parameter int T_WL    = 1,
  parameter int T_WH    = 1,
  parameter int T_WB    = 2,
  parameter int TIMEOUT = 100000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [2:0]       req_op,
  input  logic [COL_W-1:0] req_col,
  input  logic [ROW_W-1:0] req_row,
  input  logic [LEN_W-1:0] req_len,
  input  logic             erase_suspend,
  input  logic [7:0]       wr_data,
  input  logic             wr_valid,
  output logic             wr_ready,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  output logic             done,
  output logic [7:0]       status,
  output logic             timeout_err,
  output logic             nand_ce_n,
  output logic             nand_cle,
  output logic             nand_ale,
  output logic             nand_we_n,
  output logic             nand_re_n,
  output logic [7:0]       nand_dq_o,
  output logic             nand_dq_oe,
  input  logic [7:0]       nand_dq_i,
  input  logic             nand_rb_n
);
  typedef enum logic [3:0] {
    ST_IDLE, ST_CMD1, ST_ADDR, ST_WDATA, ST_CMD2, ST_WAIT, ST_SUSP,
    ST_RDATA, ST_SCMD, ST_SRD, ST_DONE
  } st_e;

  st_e st;
  op_e op;
  logic [COL_W-1:0] col_q;
  logic [ROW_W-1:0] row_q;
  logic [LEN_W-1:0] len_q, idx;
  logic launched, susp_done, err_q;
  logic [7:0] status_q;

  logic eng_go, eng_idle, eng_done;
  kind_e eng_kind;
  logic [7:0] eng_byte, eng_rd;
  logic rb_arm, rb_ok, rb_tmo;
  logic [1:0] nadr;
  logic last_idx, accept;

  assign nadr     = addr_count(op);
  assign last_idx = (idx == len_q - 1'b1);
  assign accept   = req_valid && req_ready;

  always_comb begin
    eng_kind = K_CMD;
    eng_byte = 8'h00;
    case (st)
      ST_CMD1:  eng_byte = first_cmd(op, col_q);
      ST_ADDR:  begin eng_kind = K_ADDR; eng_byte = addr_byte(op, col_q, row_q, idx[1:0]); end
      ST_WDATA: begin eng_kind = K_WR; eng_byte = wr_data; end
      ST_CMD2:  eng_byte = (op == OP_PROG) ? 8'h10 : 8'hD0;
      ST_SUSP:  eng_byte = 8'hB0;
      ST_SCMD:  eng_byte = 8'h70;
      ST_RDATA, ST_SRD: eng_kind = K_RD;
      default: ;
    endcase
  end

  logic issue_state;
  assign issue_state = (st != ST_IDLE) && (st != ST_WAIT) && (st != ST_DONE);
  assign wr_ready = (st == ST_WDATA) && eng_idle && !launched;
  assign eng_go   = issue_state && eng_idle && !launched && ((st != ST_WDATA) || wr_valid);
  assign rb_arm   = (st == ST_WAIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; op <= OP_STATUS; col_q <= '0; row_q <= '0; len_q <= '0;
      idx <= '0; launched <= 1'b0; susp_done <= 1'b0; err_q <= 1'b0; status_q <= '0;
    end else begin
      if (eng_go) launched <= 1'b1;
      else if (eng_done) launched <= 1'b0;
      case (st)
        ST_IDLE: if (accept) begin
          op <= op_e'(req_op); col_q <= req_col; row_q <= req_row; len_q <= req_len;
          idx <= '0; susp_done <= 1'b0; err_q <= 1'b0; st <= ST_CMD1;
        end
        ST_CMD1: if (eng_done) begin
          idx <= '0;
          if (nadr != 2'd0) st <= ST_ADDR;
          else if (op == OP_RESET) st <= ST_WAIT;
          else st <= ST_SRD;
        end
        ST_ADDR: if (eng_done) begin
          if (idx == LEN_W'(nadr) - 1'b1) begin
            idx <= '0;
            case (op)
              OP_PROG:  st <= ST_WDATA;
              OP_ERASE: st <= ST_CMD2;
              OP_ID:    st <= ST_RDATA;
              default:  st <= ST_WAIT;
            endcase
          end else idx <= idx + 1'b1;
        end
        ST_WDATA: if (eng_done) begin
          if (last_idx) st <= ST_CMD2; else idx <= idx + 1'b1;
        end
        ST_CMD2: if (eng_done) st <= ST_WAIT;
        ST_WAIT: begin
          idx <= '0;
          if (rb_tmo) begin err_q <= 1'b1; st <= ST_DONE; end
          else if (op == OP_ERASE && erase_suspend && !susp_done) st <= ST_SUSP;
          else if (rb_ok) begin
            if (op == OP_READ) st <= ST_RDATA;
            else if (op == OP_RESET) st <= ST_DONE;
            else st <= ST_SCMD;
          end
        end
        ST_SUSP: if (eng_done) begin susp_done <= 1'b1; st <= ST_WAIT; end
        ST_RDATA: if (eng_done) begin
          if (last_idx) st <= ST_DONE; else idx <= idx + 1'b1;
        end
        ST_SCMD: if (eng_done) st <= ST_SRD;
        ST_SRD: if (eng_done) begin status_q <= eng_rd; st <= ST_DONE; end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign req_ready   = (st == ST_IDLE);
  assign done        = (st == ST_DONE);
  assign status      = status_q;
  assign timeout_err = err_q;
  assign rd_valid    = eng_done && (st == ST_RDATA);
  assign rd_data     = eng_rd;
  assign nand_ce_n   = (st == ST_IDLE) || (st == ST_DONE);

  nand_bus_cycle #(.T_SETUP(T_SETUP), .T_WL(T_WL), .T_WH(T_WH)) u_cyc (
    .clk(clk), .rst_n(rst_n), .go(eng_go), .go_kind(eng_kind), .go_byte(eng_byte),
    .dq_i(nand_dq_i), .idle(eng_idle), .cyc_done(eng_done), .cle(nand_cle), .ale(nand_ale),
    .we_n(nand_we_n), .re_n(nand_re_n), .dq_o(nand_dq_o), .dq_oe(nand_dq_oe), .rd_byte(eng_rd)
  );

  nand_rb_wait #(.T_WB(T_WB), .TIMEOUT(TIMEOUT)) u_rbw (
    .clk(clk), .rst_n(rst_n), .arm(rb_arm), .rb_n(nand_rb_n), .ready_seen(rb_ok), .tmo(rb_tmo)
  );

  AST_CE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (!nand_we_n || !nand_re_n) |-> !nand_ce_n); // R1
  AST_OE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_re_n |-> !nand_dq_oe); // R1
  AST_ONE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && req_ready)); // R8
  AST_WR_PROG_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> (op == OP_PROG)); // R4
  AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !timeout_err); // R9
  AST_SUSP_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SUSP) |-> (op == OP_ERASE && !susp_done)); // R10
  AST_WAIT_RB: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_WAIT) && (op != OP_ERASE || !erase_suspend || susp_done) && !rb_tmo && $past(rb_arm)
      && nand_rb_n && rb_ok) |=> (st != ST_WAIT)); // R6
endmodule

// File: tb/nand_seq_tb.sv
module nand_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int T_SETUP = 2, T_WL = 2, T_WH = 1, T_WB = 3, TIMEOUT = 200;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, erase_suspend = 1'b0, wr_valid = 1'b0;
  logic [2:0] req_op = '0;
  logic [9:0] req_col = '0, req_len = '0;
  logic [12:0] req_row = '0;
  logic [7:0] wr_data, rd_data, status, nand_dq_o;
  logic [7:0] nand_dq_i = '0;
  logic req_ready, wr_ready, rd_valid, done, timeout_err;
  logic nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe, nand_rb_n;

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_seq #(.T_SETUP(T_SETUP), .T_WL(T_WL), .T_WH(T_WH), .T_WB(T_WB), .TIMEOUT(TIMEOUT)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_col(req_col), .req_row(req_row), .req_len(req_len), .erase_suspend(erase_suspend),
    .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready), .rd_data(rd_data),
    .rd_valid(rd_valid), .done(done), .status(status), .timeout_err(timeout_err),
    .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
    .nand_re_n(nand_re_n), .nand_dq_o(nand_dq_o), .nand_dq_oe(nand_dq_oe),
    .nand_dq_i(nand_dq_i), .nand_rb_n(nand_rb_n));

  // scoreboard queues
  logic [9:0] exp_bus[$];
  logic [7:0] exp_rd[$];
  int drv_checks = 0, drv_errs = 0, mon_checks = 0, mon_errs = 0;

  // program data source
  int wr_cnt = 0, wr_base = 0;
  function automatic logic [7:0] pdat(input int i);
    return 8'(i * 7 + 17);
  endfunction
  assign wr_data = pdat(wr_cnt - wr_base);
  always @(posedge clk) if (wr_valid && wr_ready) wr_cnt <= wr_cnt + 1;

  // device model
  int busy = 0, trig_seq = 0, seen_seq = 0, trig_len = 0;
  int busy_len = 10;
  logic [7:0] model_stat = 8'hC0;
  int mode = 0, acnt = 0, k = 0;
  logic [7:0] ptr = 0, cbyte = 0;
  assign nand_rb_n = (busy == 0);
  always @(posedge clk) begin
    if (trig_seq != seen_seq) begin seen_seq <= trig_seq; busy <= trig_len; end
    else if (busy != 0) busy <= busy - 1;
  end

  function automatic logic [7:0] ptr_off(input logic [7:0] p);
    return (p == 8'h01) ? 8'h40 : (p == 8'h50) ? 8'h80 : 8'h00;
  endfunction

  // monitor: bus events and read data, sampled at the falling clock edge
  logic we_prev = 1'b1, re_prev = 1'b1;
  int we_low = 0, re_low = 0;
  always @(negedge clk) begin
    if (!nand_we_n) we_low++;
    if (!nand_re_n) re_low++;
    if (!nand_re_n && re_prev)
      nand_dq_i = (mode == 1) ? model_stat : (mode == 2) ? 8'(8'h30 + k)
                : 8'(cbyte + k + ptr_off(ptr));
    if (nand_re_n && !re_prev) begin
      k++;
      mon_checks++;
      if (re_low != T_WL) begin mon_errs++; $display("FAIL R7 re low width %0d exp %0d", re_low, T_WL); end
      re_low = 0;
    end
    if (nand_we_n && !we_prev) begin
      mon_checks++;
      if (we_low != T_WL) begin mon_errs++; $display("FAIL R7 we low width %0d exp %0d", we_low, T_WL); end
      we_low = 0;
      mon_checks++;
      if (exp_bus.size() == 0) begin
        mon_errs++; $display("FAIL R1 unexpected bus byte %h cle %b ale %b exp none", nand_dq_o, nand_cle, nand_ale);
      end else begin
        logic [9:0] e;
        e = exp_bus.pop_front();
        if (e != {nand_cle, nand_ale, nand_dq_o} || nand_ce_n) begin
          mon_errs++;
          $display("FAIL R1-bus byte act %h exp %h ce_n %b", {nand_cle, nand_ale, nand_dq_o}, e, nand_ce_n);
        end
      end
      if (nand_cle) begin
        case (nand_dq_o)
          8'h70: mode = 1;
          8'h90: begin mode = 2; k = 0; end
          8'h00, 8'h01, 8'h50: begin mode = 3; ptr = nand_dq_o; acnt = 0; k = 0; end
          8'h10, 8'hD0, 8'hFF: begin trig_len = busy_len; trig_seq++; end
          8'hB0: begin trig_len = 3; trig_seq++; end
          default: mode = 0;
        endcase
      end else if (nand_ale && mode == 3) begin
        if (acnt == 0) cbyte = nand_dq_o;
        acnt++;
        if (acnt == 3) begin trig_len = busy_len; trig_seq++; end
      end
    end
    if (rd_valid) begin
      mon_checks++;
      if (exp_rd.size() == 0) begin mon_errs++; $display("FAIL R13 extra rd_data %h exp none", rd_data); end
      else begin
        logic [7:0] r;
        r = exp_rd.pop_front();
        if (r != rd_data) begin mon_errs++; $display("FAIL R13 rd_data act %h exp %h", rd_data, r); end
      end
    end
    we_prev = nand_we_n;
    re_prev = nand_re_n;
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    drv_checks++;
    if (!ok) begin drv_errs++; $display("FAIL %s act %0h exp %0h", what, act, exp); end
  endtask

  task automatic push(input bit c, input bit a, input logic [7:0] b);
    exp_bus.push_back({c, a, b});
  endtask

  task automatic page_addr(input logic [9:0] col, input logic [12:0] row);
    push(0, 1, col[7:0]); push(0, 1, row[7:0]); push(0, 1, {3'b000, row[12:8]});
  endtask

  task automatic run(input logic [2:0] op, input logic [9:0] col, input logic [12:0] row,
                     input logic [9:0] len, input bit chk_stat, input logic [7:0] exp_stat,
                     input bit exp_err, input string tag);
    int n;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_op = op; req_col = col; req_row = row; req_len = len; req_valid = 1'b1;
    wr_base = wr_cnt; wr_valid = (op == 3'd1);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, {tag, " R8 ready low while busy"}, req_ready, 0);
    n = 0;
    while (!done && n < 20000) begin @(negedge clk); n++; end
    wr_valid = 1'b0;
    chk(done == 1'b1, {tag, " R8 done seen"}, done, 1);
    chk(timeout_err == exp_err, {tag, " R9 timeout_err"}, timeout_err, exp_err);
    if (chk_stat) chk(status == exp_stat, {tag, " R6 status"}, status, exp_stat);
    chk(exp_bus.size() == 0, {tag, " R1 bus bytes left"}, exp_bus.size(), 0);
    chk(exp_rd.size() == 0, {tag, " R13 read bytes left"}, exp_rd.size(), 0);
    @(negedge clk);
    chk(done == 1'b0 && req_ready == 1'b1, {tag, " R8 done one cycle"}, done, 0);
  endtask

  task automatic do_read(input logic [9:0] col, input logic [12:0] row, input logic [9:0] len, input string tag);
    logic [7:0] off;
    off = (col < 10'd256) ? 8'h00 : (col < 10'd512) ? 8'h40 : 8'h80;
    push(1, 0, (col < 10'd256) ? 8'h00 : (col < 10'd512) ? 8'h01 : 8'h50); // R5 pointer
    page_addr(col, row);                                                     // R2 order
    for (int i = 0; i < len; i++) exp_rd.push_back(8'(col[7:0] + i + off));
    run(3'd0, col, row, len, 0, 0, 0, tag);
  endtask

  task automatic finish_run();
    int ch, er;
    ch = drv_checks + mon_checks;
    er = drv_errs + mon_errs;
    $display("CHECKS %0d ERRORS %0d", ch, er);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    drv_errs++;
    $display("FAIL watchdog expired act 1 exp 0");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // reset state
    chk(req_ready && nand_ce_n && nand_we_n && nand_re_n && !timeout_err && !done,
        "R8 reset idle outputs", {req_ready, nand_ce_n, nand_we_n, nand_re_n}, 4'hF);
    rst_n = 1'b1;
    @(negedge clk);

    busy_len = 10;
    do_read(10'd5, 13'h1234, 10'd4, "R5 read first half");
    do_read(10'd300, 13'h0042, 10'd2, "R5 read second half");
    do_read(10'd515, 13'h1FFF, 10'd3, "R5 read spare");

    // page program: R4
    model_stat = 8'hC0;
    push(1, 0, 8'h80); page_addr(10'd0, 13'h0ABC);
    for (int i = 0; i < 3; i++) push(0, 0, pdat(i));
    push(1, 0, 8'h10); push(1, 0, 8'h70);
    run(3'd1, 10'd0, 13'h0ABC, 10'd3, 1, 8'hC0, 0, "R4 program");

    // block erase: R3
    model_stat = 8'hC1;
    push(1, 0, 8'h60); push(0, 1, 8'h00); push(0, 1, 8'h1F); push(1, 0, 8'hD0); push(1, 0, 8'h70);
    run(3'd2, 10'd0, 13'h1F00, 10'd0, 1, 8'hC1, 0, "R3 erase");

    // erase suspended while busy: R10
    busy_len = 100; model_stat = 8'hA0; erase_suspend = 1'b1;
    push(1, 0, 8'h60); push(0, 1, 8'h80); push(0, 1, 8'h05); push(1, 0, 8'hD0);
    push(1, 0, 8'hB0); push(1, 0, 8'h70);
    run(3'd2, 10'd0, 13'h0580, 10'd0, 1, 8'hA0, 0, "R10 erase suspend");
    erase_suspend = 1'b0;

    // reset that never becomes ready: R9
    busy_len = 500;
    push(1, 0, 8'hFF);
    run(3'd5, 10'd0, 13'h0, 10'd0, 0, 0, 1, "R9 timeout");
    chk(nand_rb_n == 1'b0, "R12 device still busy", nand_rb_n, 0);

    // status while busy: R12, error cleared: R9
    model_stat = 8'h80;
    push(1, 0, 8'h70);
    run(3'd4, 10'd0, 13'h0, 10'd0, 1, 8'h80, 0, "R12 status while busy");
    while (!nand_rb_n) @(negedge clk);

    // read ID: R11
    busy_len = 10;
    push(1, 0, 8'h90); push(0, 1, 8'h00);
    exp_rd.push_back(8'h30); exp_rd.push_back(8'h31);
    run(3'd3, 10'd7, 13'h0, 10'd2, 0, 0, 0, "R11 read id");

    // reset with normal busy: R11
    push(1, 0, 8'hFF);
    run(3'd5, 10'd0, 13'h0, 10'd0, 0, 0, 0, "R11 reset");

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule